// File: doc/BRIEF.md
# Shared-Bus Microcoded Datapath

This block is a 32-bit datapath whose units exchange data over a single shared bus. Nothing inside it sequences anything. An external controller supplies a full set of control signals every cycle. Those signals decide which source drives the bus, which registers capture it, which ALU operation and immediate-extension mode apply, and which register-file entry is addressed and whether it is written.

The sources that can drive the bus are the immediate extender, the ALU, the register file and an external memory port. The bus is modelled as a gated multiplexer, not as tri-state wiring. It reads zero when no source is enabled. The instruction, operand A, operand B and memory-address registers all load from the bus. The controller receives the instruction opcode and the ALU zero flag so that it can branch on them. Memory itself lives outside the block, which only exposes an address, write data, a write strobe and a read-data input.

Top module: `busdp_core`

## Requirements
- R1: A synchronous active-high reset clears IR, A, B and MA. After reset `opcode` is 0, `mem_addr` is 0 and `zero` is 1 with operation code 0.
- R2: `bus_mon` carries the value of the single enabled source: extender (`drv_imm`), ALU (`drv_alu`), register file (`drv_reg`) or `mem_rdata` (`drv_mem`). With no source enabled it reads 0. At most one enable may be high in a cycle.
- R3: Each of IR, A, B and MA captures `bus_mon` at a rising clock edge when its load strobe is high, and keeps its value otherwise.
- R4: When several load strobes are high in one cycle, every selected register captures the same bus value.
- R5: `ext_mode` selects the immediate taken from IR[25:0]: 0 zero-fills above bits 15:0, 1 zero-fills above bits 25:0, 2 copies bit 15 into bits 31:16, and 3 copies bit 25 into bits 31:26.
- R6: `alu_op` selects the ALU result: 0 A, 1 B, 2 A+1, 3 A-1, 4 A+4, 5 A-4, 6 A+B, 7 A-B. All arithmetic wraps modulo 2^32.
- R7: `zero` is 1 exactly when the 32-bit ALU result is zero.
- R8: `reg_wr` writes `bus_mon` into the addressed entry of a 64-entry register file at the clock edge. Entry 0 always reads 0, and writes to it have no visible effect.
- R9: `reg_sel` forms the 6-bit register address as follows: 0 gives IR[15:11], 1 gives IR[20:16], 2 gives IR[25:21], 3 gives entry 32 (the PC) and 4 gives entry 31 (the link register). Codes 5 to 7 address entry 0.
- R10: `mem_addr` shows MA, `mem_wdata` shows `bus_mon`, and `mem_we` follows `mem_wr`.
- R11: `opcode` shows IR[31:26].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drv_imm | input | 1 | Extender drives bus |
| drv_alu | input | 1 | ALU drives bus |
| drv_reg | input | 1 | Register file drives bus |
| drv_mem | input | 1 | Memory read data drives bus |
| ld_ir | input | 1 | Load IR from bus |
| ld_a | input | 1 | Load A from bus |
| ld_b | input | 1 | Load B from bus |
| ld_ma | input | 1 | Load MA from bus |
| alu_op | input | 3 | ALU operation code |
| ext_mode | input | 2 | Immediate extension mode |
| reg_sel | input | 3 | Register address select |
| reg_wr | input | 1 | Register file write strobe |
| mem_wr | input | 1 | Memory write request |
| mem_rdata | input | 32 | Data returned by memory |
| mem_addr | output | 32 | Memory address (MA) |
| mem_wdata | output | 32 | Memory write data (bus) |
| mem_we | output | 1 | Memory write strobe |
| bus_mon | output | 32 | Current bus value |
| opcode | output | 6 | IR[31:26] |
| zero | output | 1 | ALU result is zero |

## Verification
Two functions can coincide in one cycle. The first is several registers loading from the bus at once. The second is a register-file write happening in the same cycle as a register capture from the bus that the ALU or memory drives. The bench provokes the first by raising all four load strobes while memory drives a single word. It then reads A and B back through ALU copy operations, MA through `mem_addr` and IR through `opcode`, and each must equal that word. For the second, the bench writes register entries while IR supplies the address fields, then changes IR and reads the entries back. This confirms that each write reached the entry its select code named.

// File: rtl/busdp_pkg.sv
package busdp_pkg;
  typedef enum logic [2:0] {
    OP_PASS_A = 3'd0, OP_PASS_B = 3'd1, OP_INC1 = 3'd2, OP_DEC1 = 3'd3,
    OP_INC4 = 3'd4, OP_DEC4 = 3'd5, OP_ADD = 3'd6, OP_SUB = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    EXT_Z16 = 2'd0, EXT_Z26 = 2'd1, EXT_S16 = 2'd2, EXT_S26 = 2'd3
  } ext_mode_e;

  typedef enum logic [2:0] {
    SEL_RD = 3'd0, SEL_RT = 3'd1, SEL_RS = 3'd2, SEL_PC = 3'd3, SEL_LINK = 3'd4
  } reg_sel_e;

  localparam int NUM_SRC = 4;
endpackage

// File: rtl/busdp_extend.sv
module busdp_extend #(
  parameter int DW = 32,
  parameter int NARROW = 16,
  parameter int WIDE = 26
) (
  input  logic [WIDE-1:0]   field,
  input  busdp_pkg::ext_mode_e mode,
  output logic [DW-1:0]     imm
);
  import busdp_pkg::*;
  localparam int HI_N = DW - NARROW;
  localparam int HI_W = DW - WIDE;

  always_comb begin
    unique case (mode)
      EXT_Z16: imm = {{HI_N{1'b0}}, field[NARROW-1:0]};
      EXT_Z26: imm = {{HI_W{1'b0}}, field};
      EXT_S16: imm = {{HI_N{field[NARROW-1]}}, field[NARROW-1:0]};
      default: imm = {{HI_W{field[WIDE-1]}}, field};
    endcase
  end
endmodule

// File: rtl/busdp_alu.sv
module busdp_alu #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]     a,
  input  logic [DW-1:0]     b,
  input  busdp_pkg::alu_op_e op,
  output logic [DW-1:0]     result,
  output logic              zero
);
  import busdp_pkg::*;
  localparam logic [DW-1:0] ONE  = DW'(1);
  localparam logic [DW-1:0] FOUR = DW'(4);

  always_comb begin
    unique case (op)
      OP_PASS_A: result = a;
      OP_PASS_B: result = b;
      OP_INC1:   result = a + ONE;
      OP_DEC1:   result = a - ONE;
      OP_INC4:   result = a + FOUR;
      OP_DEC4:   result = a - FOUR;
      OP_ADD:    result = a + b;
      default:   result = a - b;
    endcase
  end

  assign zero = (result == '0);
endmodule

// File: rtl/busdp_regfile.sv
module busdp_regfile #(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = (addr == '0) ? '0 : mem[addr];

  AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (addr == '0) |-> (rdata == '0)); // R8
endmodule

// File: rtl/busdp_core.sv
module busdp_core #(
  parameter int DW = 32,
  parameter int RAW = 6,
  parameter int PC_IDX = 32,
  parameter int LINK_IDX = 31
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          drv_imm,
  input  logic          drv_alu,
  input  logic          drv_reg,
  input  logic          drv_mem,
  input  logic          ld_ir,
  input  logic          ld_a,
  input  logic          ld_b,
  input  logic          ld_ma,
  input  logic [2:0]    alu_op,
  input  logic [1:0]    ext_mode,
  input  logic [2:0]    reg_sel,
  input  logic          reg_wr,
  input  logic          mem_wr,
  input  logic [31:0]   mem_rdata,
  output logic [31:0]   mem_addr,
  output logic [31:0]   mem_wdata,
  output logic          mem_we,
  output logic [31:0]   bus_mon,
  output logic [5:0]    opcode,
  output logic          zero
);
  import busdp_pkg::*;
  localparam int OPW = 6;
  localparam int FW  = 5;
  localparam int IMMW = DW - OPW;

  logic [DW-1:0] ir_q, a_q, b_q, ma_q;
  logic [DW-1:0] bus_v, imm_v, alu_v, reg_v;
  logic [RAW-1:0] rf_addr;
  logic alu_zero;

  // Bus: gated OR of sources, one-hot by contract
  logic [NUM_SRC-1:0] src_en;
  logic [DW-1:0]      src_val [NUM_SRC];
  logic [DW-1:0]      gated   [NUM_SRC];

  assign src_en  = {drv_mem, drv_reg, drv_alu, drv_imm};
  assign src_val[0] = imm_v;
  assign src_val[1] = alu_v;
  assign src_val[2] = reg_v;
  assign src_val[3] = mem_rdata;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_src
      assign gated[gi] = src_en[gi] ? src_val[gi] : '0;
    end
  endgenerate

  always_comb begin
    bus_v = '0;
    for (int i = 0; i < NUM_SRC; i++) bus_v = bus_v | gated[i];
  end

  // Load registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
      ma_q <= '0;
    end else begin
      if (ld_ir) ir_q <= bus_v;
      if (ld_a)  a_q  <= bus_v;
      if (ld_b)  b_q  <= bus_v;
      if (ld_ma) ma_q <= bus_v;
    end
  end

  // Register address select
  always_comb begin
    unique case (reg_sel_e'(reg_sel))
      SEL_RD:   rf_addr = RAW'(ir_q[15:11]);
      SEL_RT:   rf_addr = RAW'(ir_q[20:16]);
      SEL_RS:   rf_addr = RAW'(ir_q[25:21]);
      SEL_PC:   rf_addr = RAW'(PC_IDX);
      SEL_LINK: rf_addr = RAW'(LINK_IDX);
      default:  rf_addr = '0;
    endcase
  end

  busdp_extend #(.DW(DW), .NARROW(16), .WIDE(IMMW)) u_ext (
    .field (ir_q[IMMW-1:0]),
    .mode  (ext_mode_e'(ext_mode)),
    .imm   (imm_v)
  );

  busdp_alu #(.DW(DW)) u_alu (
    .a      (a_q),
    .b      (b_q),
    .op     (alu_op_e'(alu_op)),
    .result (alu_v),
    .zero   (alu_zero)
  );

  busdp_regfile #(.DW(DW), .AW(RAW)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_wr),
    .addr  (rf_addr),
    .wdata (bus_v),
    .rdata (reg_v)
  );

  assign bus_mon   = bus_v;
  assign mem_addr  = ma_q;
  assign mem_wdata = bus_v;
  assign mem_we    = mem_wr;
  assign opcode    = ir_q[DW-1 -: OPW];
  assign zero      = alu_zero;

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_en)); // R2
  AST_A_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    ld_a |=> (a_q == $past(bus_v))); // R3
  AST_B_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ld_b |=> $stable(b_q)); // R3
  AST_MULTI_LOAD: assert property (@(posedge clk) disable iff (rst)
    (ld_ir && ld_ma) |=> (ir_q == ma_q)); // R4
  AST_SUB_EQUAL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (alu_op == 3'd7 && a_q == b_q) |-> zero); // R7
  AST_Z16_UPPER: assert property (@(posedge clk) disable iff (rst)
    (drv_imm && ext_mode == 2'd0) |-> (bus_v[31:16] == '0)); // R5
endmodule

// File: tb/tb_busdp_core.sv
module tb_busdp_core;
  logic clk = 0, rst = 1;
  logic drv_imm = 0, drv_alu = 0, drv_reg = 0, drv_mem = 0;
  logic ld_ir = 0, ld_a = 0, ld_b = 0, ld_ma = 0;
  logic [2:0] alu_op = 0;
  logic [1:0] ext_mode = 0;
  logic [2:0] reg_sel = 0;
  logic reg_wr = 0, mem_wr = 0;
  logic [31:0] mem_rdata = 0;
  logic [31:0] mem_addr, mem_wdata, bus_mon;
  logic mem_we, zero;
  logic [5:0] opcode;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  busdp_core dut (.*);

  // {op, a, b, expected}
  localparam int NV = 10;
  localparam logic [98:0] VEC [NV] = '{
    {3'd0, 32'h1234_5678, 32'h0000_0001, 32'h1234_5678},
    {3'd1, 32'h1234_5678, 32'hCAFE_0001, 32'hCAFE_0001},
    {3'd2, 32'hFFFF_FFFF, 32'h0,         32'h0000_0000},
    {3'd3, 32'h0000_0000, 32'h0,         32'hFFFF_FFFF},
    {3'd4, 32'hFFFF_FFFE, 32'h0,         32'h0000_0002},
    {3'd5, 32'h0000_0010, 32'h0,         32'h0000_000C},
    {3'd6, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000},
    {3'd6, 32'h0000_0100, 32'h0000_0023, 32'h0000_0123},
    {3'd7, 32'h0000_0002, 32'h0000_0002, 32'h0000_0000},
    {3'd7, 32'h0000_0001, 32'h0000_0003, 32'hFFFF_FFFE}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear();
    drv_imm = 0; drv_alu = 0; drv_reg = 0; drv_mem = 0;
    ld_ir = 0; ld_a = 0; ld_b = 0; ld_ma = 0; reg_wr = 0; mem_wr = 0;
  endtask

  // inputs are set 1 ns after a rising edge; this finishes the cycle
  task automatic tick();
    @(posedge clk); #1; clear();
  endtask

  task automatic mem_load(input logic [31:0] v, input logic [3:0] ldm);
    drv_mem = 1; mem_rdata = v;
    {ld_ir, ld_a, ld_b, ld_ma} = ldm;
    tick();
  endtask

  task automatic alu_peek(input logic [2:0] op, output logic [31:0] v);
    drv_alu = 1; alu_op = op; #2; v = bus_mon; drv_alu = 0;
  endtask

  task automatic rf_write(input logic [2:0] sel, input logic [31:0] v);
    drv_mem = 1; mem_rdata = v; reg_sel = sel; reg_wr = 1; tick();
  endtask

  task automatic rf_read(input logic [2:0] sel, output logic [31:0] v);
    drv_reg = 1; reg_sel = sel; #2; v = bus_mon; drv_reg = 0;
  endtask

  initial begin
    #4_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    #2;
    // R1 reset state
    chk("R1 opcode", {26'd0, opcode}, 32'd0);
    chk("R1 mem_addr", mem_addr, 32'd0);
    alu_op = 0; #1;
    chk("R1 zero", {31'd0, zero}, 32'd1);
    chk("R2 idle bus", bus_mon, 32'd0);

    // R6 R7 table walk
    for (int i = 0; i < NV; i++) begin
      mem_load(VEC[i][95:64], 4'b0100);
      mem_load(VEC[i][63:32], 4'b0010);
      drv_alu = 1; alu_op = VEC[i][98:96]; #2;
      chk("R6 alu result", bus_mon, VEC[i][31:0]);
      chk("R7 zero flag", {31'd0, zero}, {31'd0, VEC[i][31:0] == 32'd0});
      chk("R10 wdata follows bus", mem_wdata, VEC[i][31:0]);
      drv_alu = 0;
    end

    // R5 extender, R11 opcode
    mem_load(32'hFE00_8123, 4'b1000);
    chk("R11 opcode", {26'd0, opcode}, 32'h3F);
    drv_imm = 1;
    ext_mode = 2'd0; #2; chk("R5 zero16", bus_mon, 32'h0000_8123);
    ext_mode = 2'd1; #2; chk("R5 zero26", bus_mon, 32'h0200_8123);
    ext_mode = 2'd2; #2; chk("R5 sign16", bus_mon, 32'hFFFF_8123);
    ext_mode = 2'd3; #2; chk("R5 sign26", bus_mon, 32'hFE00_8123);
    drv_imm = 0;
    mem_load(32'h01FF_7FFF, 4'b1000);
    chk("R11 opcode zero", {26'd0, opcode}, 32'h0);
    drv_imm = 1;
    ext_mode = 2'd2; #2; chk("R5 sign16 positive", bus_mon, 32'h0000_7FFF);
    ext_mode = 2'd3; #2; chk("R5 sign26 positive", bus_mon, 32'h01FF_7FFF);
    drv_imm = 0;

    // R4 multi-load, R3 hold
    mem_load(32'hA5C3_1E0F, 4'b1111);
    chk("R4 MA", mem_addr, 32'hA5C3_1E0F);
    chk("R4 IR", {26'd0, opcode}, {26'd0, 6'h29});
    alu_peek(3'd0, v); chk("R4 A", v, 32'hA5C3_1E0F);
    alu_peek(3'd1, v); chk("R4 B", v, 32'hA5C3_1E0F);
    mem_load(32'h1111_2222, 4'b0000);
    chk("R3 MA holds", mem_addr, 32'hA5C3_1E0F);
    alu_peek(3'd0, v); chk("R3 A holds", v, 32'hA5C3_1E0F);
    mem_load(32'h0BAD_F00D, 4'b0001);
    chk("R3 MA loads alone", mem_addr, 32'h0BAD_F00D);
    alu_peek(3'd1, v); chk("R3 B unchanged", v, 32'hA5C3_1E0F);

    // R8 R9 register file; IR rs=3 rt=5 rd=7
    mem_load(32'h0065_3800, 4'b1000);
    rf_write(3'd0, 32'h0000_1111);
    rf_write(3'd1, 32'h0000_2222);
    rf_write(3'd2, 32'h0000_3333);
    rf_write(3'd3, 32'h0000_4444);
    rf_write(3'd4, 32'h0000_5555);
    rf_read(3'd0, v); chk("R9 rd", v, 32'h0000_1111);
    rf_read(3'd1, v); chk("R9 rt", v, 32'h0000_2222);
    rf_read(3'd2, v); chk("R9 rs", v, 32'h0000_3333);
    rf_read(3'd3, v); chk("R9 pc", v, 32'h0000_4444);
    rf_read(3'd4, v); chk("R9 link", v, 32'h0000_5555);
    // IR rs=7 rt=31 rd=0
    mem_load(32'h00FF_0000, 4'b1000);
    rf_read(3'd2, v); chk("R9 rd write reached entry 7", v, 32'h0000_1111);
    rf_read(3'd1, v); chk("R9 link is entry 31", v, 32'h0000_5555);
    rf_write(3'd0, 32'hDEAD_BEEF);
    rf_read(3'd0, v); chk("R8 entry 0 reads zero", v, 32'h0);
    rf_read(3'd6, v); chk("R9 spare code entry 0", v, 32'h0);
    // write and load in same cycle: ALU drives, A captures, reg written
    mem_load(32'h0000_0040, 4'b0100);
    drv_alu = 1; alu_op = 3'd4; reg_sel = 3'd3; reg_wr = 1; ld_a = 1; tick();
    rf_read(3'd3, v); chk("R8 pc written from alu", v, 32'h0000_0044);
    alu_peek(3'd0, v); chk("R3 A captured same cycle", v, 32'h0000_0044);

    // R10 memory port
    mem_wr = 1; #2;
    chk("R10 mem_we", {31'd0, mem_we}, 32'd1);
    mem_wr = 0; #2;
    chk("R10 mem_we low", {31'd0, mem_we}, 32'd0);
    chk("R10 mem_addr is MA", mem_addr, 32'h0BAD_F00D);

    // R1 reset again clears registers
    rst = 1; tick(); rst = 0; #2;
    chk("R1 MA cleared", mem_addr, 32'd0);
    alu_peek(3'd0, v); chk("R1 A cleared", v, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule